// File: doc/BRIEF.md
# Multi-level page table walker

This block turns a virtual page address into an absolute address by reading a chain of translation tables held in memory. A request carries a virtual address, an access kind (read, write or instruction fetch), an address-space mode, a translation-enable flag and an addressing-width flag. The mode picks one of three table designators, which are supplied as inputs. The type field of that designator selects the first table level. From there the walker passes through up to three region levels and a segment level, and it ends with a page-table entry.

Table entries are fetched one at a time as 64-bit words over a request/valid memory port. The result comes back as a single-cycle `done` pulse. It carries a page-aligned absolute address, read/write/execute permission bits, a fault code and a fault identifier. Low real addresses are relocated by a prefix value before they are returned. Requests that arrive while a walk is in progress are ignored.

Top module: `tblwalk_top`

## Requirements
- R1: `req_mode_i` selects the designator: 0 uses `cr_primary_i`, 1 uses `cr_secondary_i` and 2 uses `cr_home_i`. The value 3 ends the request at once with fault 1, identifier 0 and no memory read.
- R2: Bits [3:2] of the designator give its type: 3 is region-first, 2 is region-second, 1 is region-third and 0 is segment. Region-first accepts any address. The other types fault when any of the top 11, 22 or 33 address bits are set. Such a fault is reported as fault 1 with no memory read.
- R3: The first table read is at the designator origin (entry with bits [11:0] cleared). The offset is `(va>>50)&0x3FF8` for a region-first table, `(va>>39)&0x3FF8` for region-second, `(va>>28)&0x3FF8` for region-third, `(va>>17)&0x3FF8` for a segment table and `(va>>9)&0x7F8` for a page table. The origin of each later table comes from the entry just read: bits [11:0] are cleared, except that a segment entry has only bits [10:0] cleared.
- R4: A region or segment entry with bit 5 set ends the walk with fault 2.
- R5: A region or segment entry must carry in bits [3:2] its own level (3, 2, 1 or 0, counting down from region-first). If it does not, the walk ends with fault 1.
- R6: A designator with bit 6 set maps the virtual address straight through with no memory read. The permission adjustments of R9 still apply.
- R7: A page entry with bit 10 set ends the walk with fault 3. A page entry with bit 9 set drops write permission. Otherwise the real address is the entry with bits [11:0] cleared. `perm_o` is {execute, write, read}.
- R8: A write to a page without write permission ends with fault 4, and the identifier is the space code ORed with 4. Faults 1 to 3 report the space code itself. The space code is 1 for primary, 2 for secondary and 3 for home, taken from the space actually walked. A successful result reports identifier 0. On any fault, `perm_o` and `real_addr_o` are 0.
- R9: In secondary mode, an instruction fetch is translated through the primary designator and returns execute permission only. A read or write is translated through the secondary designator and loses execute permission.
- R10: With `xlate_en_i` low, the real address is the page-aligned virtual address, `perm_o` is 3'b111 and no memory read is made.
- R11: A real address below 0x2000 has `prefix_i` added to it. A real address of 0x2000 or more is returned unchanged. This applies whether or not translation is enabled.
- R12: The low 12 address bits are always cleared. With `addr64_i` low, the address is also cut to its low 31 bits before any check or translation.
- R13: At most one table read is outstanding, and `mem_req_o` lasts one cycle. `busy_o` stays high from acceptance until `done_o` pulses for one cycle. `req_valid_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Translation request, accepted when not busy |
| req_va_i | input | 64 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_mode_i | input | 2 | Address-space mode: 0 primary, 1 secondary, 2 home |
| xlate_en_i | input | 1 | Translation enable |
| addr64_i | input | 1 | 1 for 64-bit addressing, 0 for 31-bit |
| cr_primary_i | input | 64 | Primary table designator |
| cr_secondary_i | input | 64 | Secondary table designator |
| cr_home_i | input | 64 | Home table designator |
| prefix_i | input | 64 | Prefix added to low real addresses |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 3 | 0 none, 1 specification, 2 segment, 3 page, 4 protection |
| perm_o | output | 3 | {execute, write, read} |
| real_addr_o | output | 64 | Absolute page address |
| exc_id_o | output | 3 | Fault identifier |
| mem_req_o | output | 1 | Table read strobe |
| mem_addr_o | output | 64 | Table entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Table entry read back |

## Verification
The bench builds the walker with its default parameters: 64-bit addresses, 4 KiB pages and a prefix window ending at 0x2000. These values put every table level within reach of the tests, since a region-first primary designator forces five reads per walk. The prefix window is small enough that both a relocated page and the 0x2000 boundary can be placed in tables a few pages apart. With 31-bit addressing, the top-33-bit range fault and the masking that removes it can both be hit by the same address.

// File: rtl/tblwalk_pkg.sv
package tblwalk_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        MODE_PRI  = 2'd0,
        MODE_SEC  = 2'd1,
        MODE_HOME = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_SPEC = 3'd1,
        FLT_SEG  = 3'd2,
        FLT_PAGE = 3'd3,
        FLT_PROT = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_st_e;

    // entry field positions decoded by the walker
    localparam int TYPE_LO      = 2;
    localparam int TYPE_HI      = 3;
    localparam int TBL_INV_BIT  = 5;
    localparam int DSG_REAL_BIT = 6;
    localparam int PTE_RO_BIT   = 9;
    localparam int PTE_INV_BIT  = 10;

    // top address bits that must be clear per starting type
    localparam int R2_TOP_BITS  = 11;
    localparam int R3_TOP_BITS  = 22;
    localparam int SEG_TOP_BITS = 33;

    localparam int NUM_TBL = 5;

endpackage

// File: rtl/tblwalk_space.sv
module tblwalk_space
    import tblwalk_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [1:0]        mode_i,
    input  logic [1:0]        acc_i,
    input  logic [ADDR_W-1:0] va_i,
    input  logic [ADDR_W-1:0] cr_pri_i,
    input  logic [ADDR_W-1:0] cr_sec_i,
    input  logic [ADDR_W-1:0] cr_home_i,
    output logic [ADDR_W-1:0] desig_o,
    output logic [1:0]        sbits_o,
    output logic              bad_mode_o,
    output logic              range_flt_o,
    output logic              strip_rw_o,
    output logic              strip_x_o
);

    always_comb begin
        desig_o    = '0;
        sbits_o    = 2'd0;
        bad_mode_o = 1'b0;
        strip_rw_o = 1'b0;
        strip_x_o  = 1'b0;
        case (mode_i)
            MODE_PRI: begin
                desig_o = cr_pri_i;
                sbits_o = 2'd1;
            end
            MODE_SEC: begin
                if (acc_i == ACC_FETCH) begin
                    desig_o    = cr_pri_i;
                    sbits_o    = 2'd1;
                    strip_rw_o = 1'b1;
                end else begin
                    desig_o   = cr_sec_i;
                    sbits_o   = 2'd2;
                    strip_x_o = 1'b1;
                end
            end
            MODE_HOME: begin
                desig_o = cr_home_i;
                sbits_o = 2'd3;
            end
            default: bad_mode_o = 1'b1;
        endcase
    end

    always_comb begin
        case (desig_o[TYPE_HI:TYPE_LO])
            2'd2:    range_flt_o = |va_i[ADDR_W-1 -: R2_TOP_BITS];
            2'd1:    range_flt_o = |va_i[ADDR_W-1 -: R3_TOP_BITS];
            2'd0:    range_flt_o = |va_i[ADDR_W-1 -: SEG_TOP_BITS];
            default: range_flt_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tblwalk_index.sv
module tblwalk_index
    import tblwalk_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [2:0]        tbl_i,
    input  logic [ADDR_W-1:0] entry_i,
    input  logic [ADDR_W-1:0] va_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ORG_MASK_TBL = ~(ADDR_W'('hFFF));
    localparam logic [ADDR_W-1:0] ORG_MASK_PGT = ~(ADDR_W'('h7FF));

    logic [ADDR_W-1:0] offs [NUM_TBL];
    logic [ADDR_W-1:0] origin;

    // table 0 is the page table, 1 the segment table, 2..4 region tables
    for (genvar g = 0; g < NUM_TBL; g++) begin : g_off
        localparam int SH = (g == 0) ? 9 : (17 + 11 * (g - 1));
        localparam logic [ADDR_W-1:0] MK = (g == 0) ? ADDR_W'('h7F8) : ADDR_W'('h3FF8);
        assign offs[g] = (va_i >> SH) & MK;
    end

    always_comb begin
        origin = (tbl_i == 3'd0) ? (entry_i & ORG_MASK_PGT) : (entry_i & ORG_MASK_TBL);
        addr_o = origin;
        if (tbl_i < 3'(NUM_TBL))
            addr_o = origin + offs[tbl_i];
    end

endmodule

// File: rtl/tblwalk_fsm.sv
module tblwalk_fsm
    import tblwalk_pkg::*;
#(
    parameter int                ADDR_W     = 64,
    parameter int                PAGE_SHIFT = 12,
    parameter logic [ADDR_W-1:0] LOW_LIMIT  = 'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] va_i,
    input  logic [1:0]        acc_i,
    input  logic              xlate_en_i,
    input  logic [ADDR_W-1:0] desig_i,
    input  logic [1:0]        sbits_i,
    input  logic              bad_mode_i,
    input  logic              range_flt_i,
    input  logic              strip_rw_i,
    input  logic              strip_x_i,
    input  logic [ADDR_W-1:0] prefix_i,
    input  logic              mem_rvalid_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic              mem_req_o,
    output logic [2:0]        tbl_o,
    output logic [ADDR_W-1:0] cur_o,
    output logic [ADDR_W-1:0] va_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [2:0]        fault_o,
    output logic [2:0]        perm_o,
    output logic [ADDR_W-1:0] real_o,
    output logic [2:0]        exc_o
);

    localparam logic [ADDR_W-1:0] PG_MASK = {ADDR_W{1'b1}} << PAGE_SHIFT;

    typedef struct packed {
        walk_st_e          st;
        logic [2:0]        tbl;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] va;
        logic [1:0]        acc;
        logic [1:0]        sbits;
        logic              strip_rw;
        logic              strip_x;
        logic              done;
        fault_e            flt;
        logic [2:0]        perm;
        logic [ADDR_W-1:0] ra;
        logic [2:0]        exc;
    } walk_t;

    walk_t s_d, s_q;

    function automatic logic [ADDR_W-1:0] relocate(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] pfx);
        return (a < LOW_LIMIT) ? (a + pfx) : a;
    endfunction

    function automatic logic [2:0] trim(input logic [2:0] p, input logic srw, input logic sx);
        logic [2:0] r;
        r = p;
        if (srw) r[1:0] = 2'b00;
        if (sx)  r[2]   = 1'b0;
        return r;
    endfunction

    always_comb begin
        logic wr_ok;
        s_d      = s_q;
        s_d.done = 1'b0;
        wr_ok    = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    s_d.va       = va_i;
                    s_d.acc      = acc_i;
                    s_d.sbits    = sbits_i;
                    s_d.strip_rw = xlate_en_i & strip_rw_i;
                    s_d.strip_x  = xlate_en_i & strip_x_i;
                    s_d.done     = 1'b1;
                    s_d.flt      = FLT_NONE;
                    s_d.perm     = 3'b000;
                    s_d.ra       = '0;
                    s_d.exc      = 3'd0;
                    if (!xlate_en_i) begin
                        s_d.perm = 3'b111;
                        s_d.ra   = relocate(va_i, prefix_i);
                    end else if (bad_mode_i) begin
                        s_d.flt = FLT_SPEC;
                    end else if (range_flt_i) begin
                        s_d.flt = FLT_SPEC;
                        s_d.exc = {1'b0, sbits_i};
                    end else if (desig_i[DSG_REAL_BIT]) begin
                        s_d.perm = trim(3'b111, strip_rw_i, strip_x_i);
                        s_d.ra   = relocate(va_i, prefix_i);
                    end else begin
                        s_d.done = 1'b0;
                        s_d.cur  = desig_i;
                        s_d.tbl  = {1'b0, desig_i[TYPE_HI:TYPE_LO]} + 3'd1;
                        s_d.st   = ST_REQ;
                    end
                end
            end
            ST_REQ: s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    s_d.st = ST_IDLE;
                    if (s_q.tbl != 3'd0) begin
                        if (mem_rdata_i[TBL_INV_BIT]) begin
                            s_d.done = 1'b1;
                            s_d.flt  = FLT_SEG;
                            s_d.exc  = {1'b0, s_q.sbits};
                        end else if ({1'b0, mem_rdata_i[TYPE_HI:TYPE_LO]} != (s_q.tbl - 3'd1)) begin
                            s_d.done = 1'b1;
                            s_d.flt  = FLT_SPEC;
                            s_d.exc  = {1'b0, s_q.sbits};
                        end else begin
                            s_d.cur = mem_rdata_i;
                            s_d.tbl = s_q.tbl - 3'd1;
                            s_d.st  = ST_REQ;
                        end
                    end else begin
                        s_d.done = 1'b1;
                        wr_ok    = !mem_rdata_i[PTE_RO_BIT];
                        if (mem_rdata_i[PTE_INV_BIT]) begin
                            s_d.flt = FLT_PAGE;
                            s_d.exc = {1'b0, s_q.sbits};
                        end else if ((s_q.acc == ACC_WRITE) && !wr_ok) begin
                            s_d.flt = FLT_PROT;
                            s_d.exc = {1'b1, s_q.sbits};
                        end else begin
                            s_d.perm = trim({1'b1, wr_ok, 1'b1}, s_q.strip_rw, s_q.strip_x);
                            s_d.ra   = relocate(mem_rdata_i & PG_MASK, prefix_i);
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, flt: FLT_NONE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_o = (s_q.st == ST_REQ);
    assign tbl_o     = s_q.tbl;
    assign cur_o     = s_q.cur;
    assign va_o      = s_q.va;
    assign busy_o    = (s_q.st != ST_IDLE);
    assign done_o    = s_q.done;
    assign fault_o   = s_q.flt;
    assign perm_o    = s_q.perm;
    assign real_o    = s_q.ra;
    assign exc_o     = s_q.exc;

    a_r13_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r13_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid_i) |=> (busy_o || done_o));

    a_r8_prot_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == FLT_PROT) |-> (s_q.acc == ACC_WRITE && exc_o[2]));

    a_r9_fetch_no_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == FLT_NONE && s_q.strip_rw) |-> (perm_o[1:0] == 2'b00));

    a_r7_write_has_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == FLT_NONE && s_q.acc == ACC_WRITE) |-> perm_o[1]);

endmodule

// File: rtl/tblwalk_top.sv
module tblwalk_top
    import tblwalk_pkg::*;
#(
    parameter int                ADDR_W     = 64,
    parameter int                PAGE_SHIFT = 12,
    parameter logic [ADDR_W-1:0] LOW_LIMIT  = 'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_va_i,
    input  logic [1:0]        req_acc_i,
    input  logic [1:0]        req_mode_i,
    input  logic              xlate_en_i,
    input  logic              addr64_i,
    input  logic [ADDR_W-1:0] cr_primary_i,
    input  logic [ADDR_W-1:0] cr_secondary_i,
    input  logic [ADDR_W-1:0] cr_home_i,
    input  logic [ADDR_W-1:0] prefix_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [2:0]        fault_o,
    output logic [2:0]        perm_o,
    output logic [ADDR_W-1:0] real_addr_o,
    output logic [2:0]        exc_id_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [ADDR_W-1:0] mem_rdata_i
);

    localparam logic [ADDR_W-1:0] PG_MASK  = {ADDR_W{1'b1}} << PAGE_SHIFT;
    localparam logic [ADDR_W-1:0] A31_MASK = ADDR_W'('h7FFF_FFFF);

    logic [ADDR_W-1:0] va_m;
    logic [ADDR_W-1:0] desig;
    logic [1:0]        sbits;
    logic              bad_mode, range_flt, strip_rw, strip_x;
    logic [2:0]        tbl;
    logic [ADDR_W-1:0] cur, va_q;

    assign va_m = (addr64_i ? req_va_i : (req_va_i & A31_MASK)) & PG_MASK;

    tblwalk_space #(.ADDR_W(ADDR_W)) u_space (
        .mode_i      (req_mode_i),
        .acc_i       (req_acc_i),
        .va_i        (va_m),
        .cr_pri_i    (cr_primary_i),
        .cr_sec_i    (cr_secondary_i),
        .cr_home_i   (cr_home_i),
        .desig_o     (desig),
        .sbits_o     (sbits),
        .bad_mode_o  (bad_mode),
        .range_flt_o (range_flt),
        .strip_rw_o  (strip_rw),
        .strip_x_o   (strip_x)
    );

    tblwalk_index #(.ADDR_W(ADDR_W)) u_index (
        .tbl_i   (tbl),
        .entry_i (cur),
        .va_i    (va_q),
        .addr_o  (mem_addr_o)
    );

    tblwalk_fsm #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .LOW_LIMIT  (LOW_LIMIT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .va_i         (va_m),
        .acc_i        (req_acc_i),
        .xlate_en_i   (xlate_en_i),
        .desig_i      (desig),
        .sbits_i      (sbits),
        .bad_mode_i   (bad_mode),
        .range_flt_i  (range_flt),
        .strip_rw_i   (strip_rw),
        .strip_x_i    (strip_x),
        .prefix_i     (prefix_i),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .mem_req_o    (mem_req_o),
        .tbl_o        (tbl),
        .cur_o        (cur),
        .va_o         (va_q),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .fault_o      (fault_o),
        .perm_o       (perm_o),
        .real_o       (real_addr_o),
        .exc_o        (exc_id_o)
    );

    a_r3_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[2:0] == 3'b000));

endmodule

// File: tb/tblwalk_top_tb.sv
module tblwalk_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_mode = '0;
    logic        xlate_en = 1'b0;
    logic        addr64 = 1'b1;
    logic [63:0] cr_pri = 64'h1000C;
    logic [63:0] cr_sec = 64'h60000;
    logic [63:0] cr_home = 64'h80008;
    logic [63:0] prefix = 64'h90000;
    logic        busy, done, mem_req;
    logic [2:0]  fault, perm, exc_id;
    logic [63:0] real_addr, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    bit finished = 0;

    logic [63:0] mem [logic [63:0]];

    always #4 clk = ~clk;

    tblwalk_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_va_i(req_va),
        .req_acc_i(req_acc), .req_mode_i(req_mode), .xlate_en_i(xlate_en),
        .addr64_i(addr64), .cr_primary_i(cr_pri), .cr_secondary_i(cr_sec),
        .cr_home_i(cr_home), .prefix_i(prefix), .busy_o(busy), .done_o(done),
        .fault_o(fault), .perm_o(perm), .real_addr_o(real_addr), .exc_id_o(exc_id),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
        if (mem_req) rd_cnt <= rd_cnt + 1;
    end

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  acc;
        logic        en;
        logic        a64;
        logic [63:0] va;
        logic [2:0]  flt;
        logic [2:0]  perm;
        logic [63:0] ra;
        logic [2:0]  exc;
        logic [2:0]  rd;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 1'b1, 1'b1, 64'h403ABC,            3'd0, 3'd7, 64'h777000, 3'd0, 3'd5}, // R1 R3
        '{2'd0, 2'd1, 1'b1, 1'b1, 64'h403000,            3'd0, 3'd7, 64'h777000, 3'd0, 3'd5}, // R7
        '{2'd0, 2'd2, 1'b1, 1'b1, 64'h403000,            3'd0, 3'd7, 64'h777000, 3'd0, 3'd5}, // R1
        '{2'd0, 2'd1, 1'b1, 1'b1, 64'h404000,            3'd4, 3'd0, 64'h0,      3'd5, 3'd5}, // R8
        '{2'd0, 2'd0, 1'b1, 1'b1, 64'h404000,            3'd0, 3'd5, 64'h788000, 3'd0, 3'd5}, // R7
        '{2'd0, 2'd0, 1'b1, 1'b1, 64'h405000,            3'd3, 3'd0, 64'h0,      3'd1, 3'd5}, // R7
        '{2'd1, 2'd0, 1'b1, 1'b1, 64'h5000,              3'd0, 3'd3, 64'h91000,  3'd0, 3'd2}, // R9 R11
        '{2'd1, 2'd2, 1'b1, 1'b1, 64'h403000,            3'd0, 3'd4, 64'h777000, 3'd0, 3'd5}, // R9
        '{2'd1, 2'd1, 1'b1, 1'b1, 64'h5000,              3'd0, 3'd3, 64'h91000,  3'd0, 3'd2}, // R9
        '{2'd1, 2'd0, 1'b1, 1'b1, 64'h8000_5000,         3'd1, 3'd0, 64'h0,      3'd2, 3'd0}, // R2
        '{2'd1, 2'd0, 1'b1, 1'b0, 64'h8000_5000,         3'd0, 3'd3, 64'h91000,  3'd0, 3'd2}, // R12
        '{2'd2, 2'd0, 1'b1, 1'b1, 64'h0020_0000_0000_0000, 3'd1, 3'd0, 64'h0,    3'd3, 3'd0}, // R2
        '{2'd2, 2'd0, 1'b1, 1'b1, 64'h0000_0800_0000_0000, 3'd2, 3'd0, 64'h0,    3'd3, 3'd1}, // R4
        '{2'd2, 2'd0, 1'b1, 1'b1, 64'h0000_1000_0000_0000, 3'd1, 3'd0, 64'h0,    3'd3, 3'd1}, // R5
        '{2'd0, 2'd0, 1'b0, 1'b1, 64'h1234_5678,         3'd0, 3'd7, 64'h1234_5000, 3'd0, 3'd0}, // R10
        '{2'd0, 2'd0, 1'b0, 1'b1, 64'h1800,              3'd0, 3'd7, 64'h91000,  3'd0, 3'd0}, // R11
        '{2'd0, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_1ABC, 3'd0, 3'd7, 64'h91000, 3'd0, 3'd0}, // R12
        '{2'd0, 2'd0, 1'b0, 1'b1, 64'h2000,              3'd0, 3'd7, 64'h2000,   3'd0, 3'd0}, // R11
        '{2'd0, 2'd0, 1'b1, 1'b0, 64'hFFFF_FFFF_0040_3ABC, 3'd0, 3'd7, 64'h777000, 3'd0, 3'd5}  // R12
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 2:       return "R1";
            1, 4, 5:    return "R7";
            3:          return "R8";
            6, 7, 8:    return "R9";
            9, 11:      return "R2";
            12:         return "R4";
            13:         return "R5";
            14:         return "R10";
            15, 17:     return "R11";
            default:    return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] m, input logic [1:0] a, input logic en,
                           input logic w64, input logic [63:0] va);
        int guard;
        @(negedge clk);
        req_mode  = m;
        req_acc   = a;
        xlate_en  = en;
        addr64    = w64;
        req_va    = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic full_check(input string tag, input logic [2:0] ef, input logic [2:0] ep,
                              input logic [63:0] er, input logic [2:0] ee, input int erd,
                              input int rd0);
        chk(tag, "done", done, 1'b1);
        chk(tag, "fault", fault, ef);
        chk(tag, "perm", perm, ep);
        chk(tag, "real", real_addr, er);
        chk(tag, "exc", exc_id, ee);
        chk(tag, "reads", rd_cnt - rd0, erd);
    endtask

    initial begin
        // tables, offsets per R3
        mem[64'h10000] = 64'h2000C;             // region-first entry, type 3
        mem[64'h20000] = 64'h30008;             // region-second entry, type 2
        mem[64'h30000] = 64'h40004;             // region-third entry, type 1
        mem[64'h40020] = 64'h50800;             // segment entry, 2K-aligned page table
        mem[64'h50818] = 64'h777000;            // valid page
        mem[64'h50820] = 64'h788200;            // read-only page
        mem[64'h50828] = 64'h400;               // invalid page
        mem[64'h60000] = 64'h70000;             // secondary segment entry
        mem[64'h70028] = 64'h1000;              // low real page (prefix)
        mem[64'h80010] = 64'h28;                // invalid region-second entry
        mem[64'h80020] = 64'h90000;             // wrong type
    end

    initial begin
        int rd0;
        repeat (3) @(negedge clk);
        // reset state
        chk("R13", "reset busy", busy, 1'b0);
        chk("R13", "reset done", done, 1'b0);
        chk("R13", "reset mem_req", mem_req, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            rd0 = rd_cnt;
            run_req(VECS[i].mode, VECS[i].acc, VECS[i].en, VECS[i].a64, VECS[i].va);
            full_check(tag_of(i), VECS[i].flt, VECS[i].perm, VECS[i].ra,
                       VECS[i].exc, int'(VECS[i].rd), rd0);
        end

        // R1: reserved mode
        rd0 = rd_cnt;
        run_req(2'd3, 2'd0, 1'b1, 1'b1, 64'h403000);
        full_check("R1", 3'd1, 3'd0, 64'h0, 3'd0, 0, rd0);

        // R6: real-space designator
        cr_home = 64'h4C;
        rd0 = rd_cnt;
        run_req(2'd2, 2'd1, 1'b1, 1'b1, 64'h1234_5000);
        full_check("R6", 3'd0, 3'd7, 64'h1234_5000, 3'd0, 0, rd0);
        cr_sec = 64'h48;
        rd0 = rd_cnt;
        run_req(2'd1, 2'd0, 1'b1, 1'b1, 64'h3000);
        full_check("R6", 3'd0, 3'd3, 64'h3000, 3'd0, 0, rd0);
        cr_home = 64'h80008;
        cr_sec  = 64'h60000;

        // R13: requests during a walk are ignored
        rd0 = rd_cnt;
        @(negedge clk);
        req_mode = 2'd0; req_acc = 2'd0; xlate_en = 1'b1; addr64 = 1'b1;
        req_va = 64'h403000; req_valid = 1'b1;
        @(negedge clk);
        req_va = 64'h405000;
        chk("R13", "busy after accept", busy, 1'b1);
        repeat (3) @(negedge clk);
        chk("R13", "busy mid walk", busy, 1'b1);
        req_valid = 1'b0;
        begin
            int guard = 0;
            while (!done && guard < 200) begin
                @(negedge clk);
                guard++;
            end
        end
        full_check("R13", 3'd0, 3'd7, 64'h777000, 3'd0, 5, rd0);
        chk("R13", "busy at done", busy, 1'b0);
        @(negedge clk);
        chk("R13", "done pulse width", done, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R13 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule